// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block connects an internal clocked request port to an external asynchronous static RAM with 2,048 byte locations. A requester presents one access at a time: a valid/ready handshake with a write flag, an 11-bit address and a write byte. Reads return the stored byte together with a single-cycle valid strobe. Writes complete silently.

On the memory side the controller drives the address and the three active-low strobes (chip select, output enable and write enable). It also controls the shared data bus through separate output, input and drive-enable signals, so that pads can be added outside it. Every phase length is derived from nanosecond limits held in parameters and from the clock period parameter. Each count is the limit divided by the period, rounded up, and never less than one cycle. The sequencing keeps the address frozen whenever write enable is low. It also keeps the controller off the data bus until the memory's outputs have had time to float after a read.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset, and whenever reset is asserted, `req_ready` is 1, all three memory strobes are 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the access is finished, and it is 0 for every cycle in which chip select is low. Request inputs that change while `req_ready` is 0 have no effect on the access in progress.
- R3: A read holds chip select and output enable low and write enable high for its whole length, and it never asserts `mem_dq_oe`.
- R4: A read samples `mem_dq_in` on the last cycle of its access phase. The access phase lasts max(ceil(100/P), ceil(40/P)) cycles, which is 10 at P = 10 ns. In the cycle after that last cycle, `rsp_valid` is 1 for exactly one cycle and `rsp_rdata` holds the sampled byte.
- R5: A read keeps chip select low for max(access phase, ceil(100/P)) cycles, which is 10 at the defaults.
- R6: A write keeps output enable high throughout. It holds write enable low for max(ceil(60/P), ceil(30/P), ceil(80/P)) consecutive cycles (8 at the defaults), and it drives `mem_dq_out` equal to the request byte with `mem_dq_oe` at 1 for every cycle that write enable is low.
- R7: `mem_addr` equals the accepted address for the whole time chip select is low, and it never changes while write enable is low.
- R8: After output enable rises at the end of a read, `mem_dq_oe` stays 0 for at least ceil(40/P) cycles (4 at the defaults).
- R9: A write starts with at least one cycle of chip select low and write enable high. It keeps chip select low for at least ceil(100/P) cycles, exactly 10 when no read turnaround is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe: read data valid |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 11 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_in | input | 8 | Byte seen on the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The stimulus covers writes to the lowest, highest and a middle address, followed by reads of each. A read of a location never written tells a real bus sample apart from stale register contents. A write straight after a read is separated from a write after a write, so the bench can see both the extra float wait and the exact minimum write length. A read is also held busy while the request inputs change to a write at another address, which shows whether busy-time inputs are ignored. Reset is asserted in the middle of a write pulse to confirm that every strobe returns to idle at once.

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W        = 11,
  parameter int DATA_W        = 8,
  parameter int T_RC_NS       = 100,
  parameter int T_AA_NS       = 100,
  parameter int T_OE_NS       = 40,
  parameter int T_WC_NS       = 100,
  parameter int T_WP_NS       = 60,
  parameter int T_AW_NS       = 80,
  parameter int T_DW_NS       = 30,
  parameter int T_WR_NS       = 10,
  parameter int T_DH_NS       = 5,
  parameter int T_HZ_NS       = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_ACC  = mx(cyc(T_AA_NS), cyc(T_OE_NS));
  localparam int RD_TOT  = mx(RD_ACC, cyc(T_RC_NS));
  localparam int WP_LEN  = mx(cyc(T_WP_NS), mx(cyc(T_DW_NS), cyc(T_AW_NS)));
  localparam int WR_LEN  = mx(cyc(T_WR_NS), cyc(T_DH_NS));
  localparam int WC_LEN  = cyc(T_WC_NS);
  localparam int HZ_LEN  = cyc(T_HZ_NS);
  localparam int MAXC    = mx(mx(RD_TOT, WC_LEN), mx(WP_LEN, mx(WR_LEN, HZ_LEN)));
  localparam int CW      = $clog2(MAXC + 1) + 1;

  localparam logic [CW-1:0] K_RACC = CW'(RD_ACC - 1);
  localparam logic [CW-1:0] K_RTOT = CW'(RD_TOT - 1);
  localparam logic [CW-1:0] K_WP   = CW'(WP_LEN - 1);
  localparam logic [CW-1:0] K_WR   = CW'(WR_LEN - 1);
  localparam logic [CW-1:0] K_WC   = CW'(WC_LEN - 1);
  localparam logic [CW-1:0] K_HZ   = CW'(HZ_LEN);
  localparam logic [CW-1:0] K_ONE  = CW'(1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSET, S_WPUL, S_WREC} state_t;

  state_t            st;
  logic [CW-1:0]     cnt, tot, hz;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  assign req_ready  = (st == S_IDLE);
  assign mem_ce_n   = (st == S_IDLE);
  assign mem_oe_n   = (st != S_RD);
  assign mem_we_n   = (st != S_WPUL);
  assign mem_dq_oe  = (st == S_WPUL) || (st == S_WREC);
  assign mem_dq_out = wdata_q;
  assign mem_addr   = addr_q;
  assign rsp_valid  = rvalid_q;
  assign rsp_rdata  = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      tot      <= '0;
      hz       <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      if (hz != '0) hz <= hz - K_ONE;
      if (tot != K_WC) tot <= tot + K_ONE;
      cnt <= cnt + K_ONE;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          tot <= '0;
          if (req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            st      <= req_write ? S_WSET : S_RD;
          end
        end
        S_RD: begin
          if (cnt == K_RACC) begin
            rdata_q  <= mem_dq_in;
            rvalid_q <= 1'b1;
          end
          if (cnt == K_RTOT) begin
            st  <= S_IDLE;
            cnt <= '0;
            hz  <= K_HZ;
          end
        end
        S_WSET: begin
          if (hz <= K_ONE) begin
            st  <= S_WPUL;
            cnt <= '0;
          end
        end
        S_WPUL: begin
          if (cnt == K_WP) begin
            st  <= S_WREC;
            cnt <= '0;
          end
        end
        S_WREC: begin
          if (cnt >= K_WR && tot == K_WC) begin
            st  <= S_IDLE;
            cnt <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid));

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  p_read_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && mem_we_n && !mem_ce_n));

  p_rvalid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_write_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n));

  p_addr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $stable(mem_addr));

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> !mem_dq_oe);

  p_ce_before_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_ce_n));

endmodule

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
  localparam int CLK_NS   = 10;
  localparam int RACC_CYC = 10;
  localparam int RD_CYC   = 10;
  localparam int WP_CYC   = 8;
  localparam int WC_CYC   = 10;
  localparam int HZ_CYC   = 4;

  localparam logic [19:0] VEC [8] = '{
    {1'b1, 11'h000, 8'hA5},
    {1'b1, 11'h7FF, 8'h5A},
    {1'b1, 11'h123, 8'h3C},
    {1'b0, 11'h000, 8'hA5},
    {1'b0, 11'h7FF, 8'h5A},
    {1'b1, 11'h123, 8'hC3},
    {1'b0, 11'h123, 8'hC3},
    {1'b0, 11'h400, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_out, mem_dq_in;
  logic [10:0] mem_addr;
  logic [7:0]  mem [2048];
  int errors = 0, checks = 0, oe_hi_run = 0;

  always #(CLK_NS/2) clk = ~clk;

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem[mem_addr] : 8'h00;

  sram_async_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
  endtask

  task automatic idle_check(input string req);
    chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
        req, "idle outputs", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 6'b111100);
  endtask

  task automatic run_op(input logic w, input logic [10:0] a, input logic [7:0] d, input bit after_read);
    int idx = 0, ce_cyc = 0, we_cyc = 0, rv_cnt = 0, rv_idx = 0, gap = -1;
    bit bad_ready = 0, bad_addr = 0, bad_strobe = 0, bad_dq = 0, first_we_low = 0;
    logic [7:0] got = 0;
    tick();
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    tick();
    req_valid = 0;
    while (!mem_ce_n) begin
      idx++; ce_cyc++;
      if (req_ready) bad_ready = 1;
      if (mem_addr != a) bad_addr = 1;
      if (w) begin
        if (!mem_oe_n) bad_strobe = 1;
        if (idx == 1 && !mem_we_n) first_we_low = 1;
        if (!mem_we_n) begin
          we_cyc++;
          if (!mem_dq_oe || mem_dq_out != d) bad_dq = 1;
          mem[mem_addr] = mem_dq_out;
        end
        if (mem_dq_oe && gap < 0) gap = oe_hi_run;
      end else begin
        if (mem_oe_n || !mem_we_n) bad_strobe = 1;
        if (mem_dq_oe) bad_dq = 1;
      end
      if (rsp_valid) begin rv_cnt++; rv_idx = idx; got = rsp_rdata; end
      tick();
    end
    idx++;
    if (rsp_valid) begin rv_cnt++; rv_idx = idx; got = rsp_rdata; end
    chk(!bad_ready, "R2", "ready low while busy", bad_ready, 0);
    chk(req_ready, "R2", "ready after access", req_ready, 1);
    chk(!bad_addr, "R7", "address held", bad_addr, 0);
    if (w) begin
      chk(!bad_strobe, "R6", "oe high in write", bad_strobe, 0);
      chk(we_cyc == WP_CYC, "R6", "we low cycles", we_cyc, WP_CYC);
      chk(!bad_dq, "R6", "data driven in pulse", bad_dq, 0);
      chk(!first_we_low, "R9", "we high in first cycle", first_we_low, 0);
      if (after_read) begin
        chk(ce_cyc >= WC_CYC, "R9", "write length after read", ce_cyc, WC_CYC);
        chk(gap >= HZ_CYC + 1, "R8", "float wait before drive", gap, HZ_CYC + 1);
      end else
        chk(ce_cyc == WC_CYC, "R9", "write length", ce_cyc, WC_CYC);
      chk(rv_cnt == 0, "R4", "no rvalid on write", rv_cnt, 0);
    end else begin
      chk(!bad_strobe, "R3", "read strobes", bad_strobe, 0);
      chk(!bad_dq, "R3", "no drive in read", bad_dq, 0);
      chk(ce_cyc == RD_CYC, "R5", "read length", ce_cyc, RD_CYC);
      chk(rv_cnt == 1, "R4", "rvalid count", rv_cnt, 1);
      chk(rv_idx == RACC_CYC + 1, "R4", "rvalid cycle", rv_idx, RACC_CYC + 1);
      chk(got == d, "R4", "read data", got, d);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit prev_read = 0;
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    repeat (3) tick();
    idle_check("R1");
    rst_n = 1;
    tick();
    idle_check("R1");

    for (int v = 0; v < 8; v++) begin
      run_op(VEC[v][19], VEC[v][18:8], VEC[v][7:0], prev_read);
      prev_read = !VEC[v][19];
    end

    begin
      bit moved = 0, wrote = 0;
      tick();
      req_valid = 1; req_write = 0; req_addr = 11'h7FF; req_wdata = 8'hEE;
      tick();
      req_write = 1; req_addr = 11'h001;
      while (!mem_ce_n) begin
        if (mem_addr != 11'h7FF) moved = 1;
        if (!mem_we_n) wrote = 1;
        tick();
      end
      req_valid = 0;
      chk(!moved, "R2", "busy address ignored", moved, 0);
      chk(!wrote, "R2", "busy write ignored", wrote, 0);
      chk(rsp_rdata == 8'h5A, "R2", "original read kept", rsp_rdata, 8'h5A);
      tick();
      chk(mem_ce_n, "R2", "no extra access", mem_ce_n, 1);
    end

    run_op(1'b1, 11'h001, 8'h11, 1'b0);
    run_op(1'b0, 11'h001, 8'h11, 1'b0);

    tick();
    req_valid = 1; req_write = 1; req_addr = 11'h010; req_wdata = 8'h77;
    tick();
    req_valid = 0;
    repeat (4) tick();
    chk(!mem_we_n, "R6", "pulse under way", mem_we_n, 0);
    rst_n = 0;
    tick();
    idle_check("R1");
    rst_n = 1;
    tick();
    idle_check("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule